// File: doc/BRIEF.md
# Ethernet Controller Register Bank

This block holds the software-visible control and status registers of a gigabit Ethernet controller. It connects to a single-cycle 32-bit register bus with a byte address, a write strobe, write data and combinational read data. The registers cover device control and status, the interrupt cause and mask, two descriptor rings (receive and transmit), and the split of the on-chip packet buffer. A write is not always a plain store. Ring base and length writes drop their alignment bits. A buffer-split write derives the transmit share from the receive share. The cause and mask registers each have set and clear ports.

PHY management requests are answered inside the block. A write to the management register fills the data field at once with a fixed value for the PHY register addressed and raises a ready flag. A request the block cannot serve is marked with an error flag. Addresses that belong to filter tables, address tables and counters decode without error. Those that belong to nothing raise `bus_err`.

Top module: `nic_csr_bank`

## Requirements
- R1: After reset: control reads 0x0000_0A09 (full duplex bit 0, link reset bit 3, speed [9:8]=2, force speed bit 11). Status reads 0x0000_00C1 (full duplex bit 0, speed [7:6]=3). Buffer split reads 0x0010_0030. Cause, mask, management and all ring registers read 0.
- R2: Control (0x0000) and status (0x0008) store the full written word.
- R3: Each ring (receive at 0x2800, transmit at 0x3800) has base-low +0x0, base-high +0x4, length +0x8, head +0x10 and tail +0x18. Base-low writes clear bits [3:0] and length writes clear bits [6:0]. The other ring registers store the full word. The two rings do not affect each other.
- R4: A write to the buffer split (0x1000) sets the receive share [15:0] to wdata[15:0] and sets the transmit share [31:16] to (64 - receive share) modulo 2^16.
- R5: A write to cause (0x00C0) replaces it. A write to cause-set (0x00C8) ORs the data into it.
- R6: A write to mask-set (0x00D0) ORs the data into the mask. A write to mask-clear (0x00D8) clears each mask bit set in the data. The mask reads back at 0x00D0.
- R7: A write to management (0x0020) stores op [27:26], PHY address [25:21], register [20:16] and interrupt-request [29] from the data, and sets ready [28]. For PHY address 1 with bit 29 clear, data [15:0] becomes 0x796D (register 1), 0x02A8 (2), 0x0380 (3), 0x7C00 (10), 0x3000 (15), 0x0180 (20), or 0 for any other register.
- R8: A management write with PHY address other than 1, or with bit 29 set, sets error [30], sets ready, and loads data 0. A well-formed write clears error.
- R9: Writes to 0x0028, 0x002C, 0x0030, 0x0038, 0x0410, 0x0458, 0x0E00 (LED) and 0x5800 (wake-up) change no register. LED and wake-up read 0.
- R10: Reads within 0x4000-0x40FF (counters), 0x5200-0x53FF, 0x5400-0x547F and 0x5600-0x57FF return 0 without error. Writes to the last three ranges are accepted and discarded.
- R11: `bus_err` is high, and read data is 0, for any unaligned address, any address outside the decoded set, a read of a write-only address (cause-set, mask-clear, the discard-only addresses of R9 other than LED and wake-up), and a write into the counter range.
- R12: A write that raises `bus_err` changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_we | input | 1 | Write strobe; when low the access is a read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| bus_err | output | 1 | Access does not decode to a legal register for its direction |

## Verification
The hardest state to reach is a management register that holds the outcome of each PHY register in turn, together with the error flag being raised and then cleared again. The only way in is a full-word write whose fields encode the PHY address, register number and interrupt-request bit. The stimulus table therefore walks every canned PHY register, then an unknown register with stray op and data bits, then a wrong PHY address and a request with the interrupt bit set, and reads the word back after each write. The buffer split is driven with a receive share larger than 64 so that the transmit share wraps.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int SHARE_W   = 16;
    localparam int BUF_TOTAL = 64;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // decoded register addresses
    localparam addr_t A_CTRL     = 16'h0000;
    localparam addr_t A_STATUS   = 16'h0008;
    localparam addr_t A_MGMT     = 16'h0020;
    localparam addr_t A_FC_LO    = 16'h0028;
    localparam addr_t A_FC_HI    = 16'h002C;
    localparam addr_t A_FC_TYPE  = 16'h0030;
    localparam addr_t A_VLAN_ET  = 16'h0038;
    localparam addr_t A_CAUSE    = 16'h00C0;
    localparam addr_t A_CSET     = 16'h00C8;
    localparam addr_t A_MSET     = 16'h00D0;
    localparam addr_t A_MCLR     = 16'h00D8;
    localparam addr_t A_GAP      = 16'h0410;
    localparam addr_t A_AIFS     = 16'h0458;
    localparam addr_t A_LED      = 16'h0E00;
    localparam addr_t A_BUFSPLIT = 16'h1000;
    localparam addr_t A_WAKE     = 16'h5800;

    // table windows
    localparam addr_t A_STATS = 16'h4000;  localparam int STATS_BYTES = 256;
    localparam addr_t A_MCAST = 16'h5200;  localparam int MCAST_BYTES = 512;
    localparam addr_t A_RXADR = 16'h5400;  localparam int RXADR_BYTES = 128;
    localparam addr_t A_VLANT = 16'h5600;  localparam int VLANT_BYTES = 512;

    // ring layout
    localparam addr_t RING0_BASE  = 16'h2800;
    localparam addr_t RING_STRIDE = 16'h1000;
    localparam addr_t RO_BLO  = 16'h0000;
    localparam addr_t RO_BHI  = 16'h0004;
    localparam addr_t RO_LEN  = 16'h0008;
    localparam addr_t RO_HEAD = 16'h0010;
    localparam addr_t RO_TAIL = 16'h0018;
    localparam int BLO_ZERO_BITS = 4;
    localparam int LEN_ZERO_BITS = 7;

    localparam word_t CTRL_RST = 32'h0000_0A09;
    localparam word_t STAT_RST = 32'h0000_00C1;

    typedef struct packed {
        logic [SHARE_W-1:0] tx;
        logic [SHARE_W-1:0] rx;
    } bufsplit_t;

    localparam bufsplit_t SPLIT_RST = '{tx: 16'h0010, rx: 16'h0030};

    typedef struct packed {
        logic        rsv;
        logic        err;
        logic        irq_req;
        logic        ready;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  preg;
        logic [15:0] data;
    } mgmt_t;

    localparam logic [4:0] SERVED_PHY = 5'd1;

    function automatic logic [15:0] phy_value(input logic [4:0] r);
        case (r)
            5'd1:    return 16'h796D;
            5'd2:    return 16'h02A8;
            5'd3:    return 16'h0380;
            5'd10:   return 16'h7C00;
            5'd15:   return 16'h3000;
            5'd20:   return 16'h0180;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic in_span(input addr_t a, input addr_t lo, input int bytes);
        logic [31:0] aa;
        logic [31:0] ll;
        aa = 32'(a);
        ll = 32'(lo);
        return (aa >= ll) && (aa < ll + 32'(bytes));
    endfunction

    function automatic addr_t ring_base(input int idx);
        return RING0_BASE + addr_t'(idx) * RING_STRIDE;
    endfunction

endpackage

// File: rtl/nic_ring_regs.sv
module nic_ring_regs
    import nic_csr_pkg::*;
#(
    parameter addr_t BASE = 16'h2800
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t addr,
    input  logic  we,
    input  word_t wdata,
    output word_t rdata,
    output logic  hit
);
    localparam addr_t AD_BLO  = BASE + RO_BLO;
    localparam addr_t AD_BHI  = BASE + RO_BHI;
    localparam addr_t AD_LEN  = BASE + RO_LEN;
    localparam addr_t AD_HEAD = BASE + RO_HEAD;
    localparam addr_t AD_TAIL = BASE + RO_TAIL;
    localparam word_t BLO_MASK = ~word_t'((1 << BLO_ZERO_BITS) - 1);
    localparam word_t LEN_MASK = ~word_t'((1 << LEN_ZERO_BITS) - 1);

    word_t blo_q, bhi_q, len_q, head_q, tail_q;

    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        case (addr)
            AD_BLO:  rdata = blo_q;
            AD_BHI:  rdata = bhi_q;
            AD_LEN:  rdata = len_q;
            AD_HEAD: rdata = head_q;
            AD_TAIL: rdata = tail_q;
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blo_q  <= '0;
            bhi_q  <= '0;
            len_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else if (we) begin
            case (addr)
                AD_BLO:  blo_q  <= wdata & BLO_MASK;
                AD_BHI:  bhi_q  <= wdata;
                AD_LEN:  len_q  <= wdata & LEN_MASK;
                AD_HEAD: head_q <= wdata;
                AD_TAIL: tail_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
    import nic_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_cause,
    input  logic  wr_cset,
    input  logic  wr_mset,
    input  logic  wr_mclr,
    input  word_t wdata,
    output word_t cause,
    output word_t mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            if (wr_cause)     cause <= wdata;
            else if (wr_cset) cause <= cause | wdata;
            if (wr_mset)      mask  <= mask | wdata;
            else if (wr_mclr) mask  <= mask & ~wdata;
        end
    end
endmodule

// File: rtl/nic_phy_stub.sv
module nic_phy_stub
    import nic_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  word_t wdata,
    output mgmt_t mgmt
);
    mgmt_t req;
    mgmt_t nxt;
    logic  bad;

    always_comb begin
        req         = mgmt_t'(wdata);
        bad         = (req.phy != SERVED_PHY) || req.irq_req;
        nxt         = req;
        nxt.rsv     = 1'b0;
        nxt.err     = bad;
        nxt.ready   = 1'b1;
        nxt.data    = bad ? 16'h0000 : phy_value(req.preg);
    end

    always_ff @(posedge clk) begin
        if (rst)     mgmt <= '0;
        else if (wr) mgmt <= nxt;
    end
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter int N_RINGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    word_t     ctrl_q, stat_q;
    bufsplit_t split_q;
    word_t     cause_q, mask_q;
    mgmt_t     mgmt_q;

    logic  wr_fire;
    logic  rd_known, wr_known;
    word_t rd_val;

    logic  [N_RINGS-1:0] ring_hit_v;
    word_t               ring_rd_v [N_RINGS];
    logic                ring_hit;
    word_t               ring_rd;

    generate
        for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
            nic_ring_regs #(.BASE(ring_base(g))) u_ring (
                .clk   (clk),
                .rst   (rst),
                .addr  (bus_addr),
                .we    (wr_fire),
                .wdata (bus_wdata),
                .rdata (ring_rd_v[g]),
                .hit   (ring_hit_v[g])
            );
        end
    endgenerate

    always_comb begin
        ring_rd = '0;
        for (int i = 0; i < N_RINGS; i++) ring_rd = ring_rd | ring_rd_v[i];
        ring_hit = |ring_hit_v;
    end

    always_comb begin
        rd_known = 1'b1;
        wr_known = 1'b1;
        rd_val   = '0;
        case (bus_addr)
            A_CTRL:     rd_val = ctrl_q;
            A_STATUS:   rd_val = stat_q;
            A_MGMT:     rd_val = mgmt_q;
            A_CAUSE:    rd_val = cause_q;
            A_MSET:     rd_val = mask_q;
            A_BUFSPLIT: rd_val = split_q;
            A_WAKE, A_LED: rd_val = '0;
            A_CSET, A_MCLR, A_FC_LO, A_FC_HI, A_FC_TYPE, A_VLAN_ET, A_GAP, A_AIFS:
                rd_known = 1'b0;
            default: begin
                if (ring_hit) begin
                    rd_val = ring_rd;
                end else if (in_span(bus_addr, A_MCAST, MCAST_BYTES) ||
                             in_span(bus_addr, A_RXADR, RXADR_BYTES) ||
                             in_span(bus_addr, A_VLANT, VLANT_BYTES)) begin
                    rd_val = '0;
                end else if (in_span(bus_addr, A_STATS, STATS_BYTES)) begin
                    wr_known = 1'b0;
                end else begin
                    rd_known = 1'b0;
                    wr_known = 1'b0;
                end
            end
        endcase
    end

    assign bus_err   = (bus_addr[1:0] != 2'b00) || (bus_we ? !wr_known : !rd_known);
    assign bus_rdata = bus_err ? '0 : rd_val;
    assign wr_fire   = bus_we && !bus_err;

    nic_irq_regs u_irq (
        .clk      (clk),
        .rst      (rst),
        .wr_cause (wr_fire && bus_addr == A_CAUSE),
        .wr_cset  (wr_fire && bus_addr == A_CSET),
        .wr_mset  (wr_fire && bus_addr == A_MSET),
        .wr_mclr  (wr_fire && bus_addr == A_MCLR),
        .wdata    (bus_wdata),
        .cause    (cause_q),
        .mask     (mask_q)
    );

    nic_phy_stub u_phy (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_fire && bus_addr == A_MGMT),
        .wdata (bus_wdata),
        .mgmt  (mgmt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            stat_q  <= STAT_RST;
            split_q <= SPLIT_RST;
        end else if (wr_fire) begin
            case (bus_addr)
                A_CTRL:   ctrl_q <= bus_wdata;
                A_STATUS: stat_q <= bus_wdata;
                A_BUFSPLIT: begin
                    split_q.rx <= bus_wdata[SHARE_W-1:0];
                    split_q.tx <= SHARE_W'(BUF_TOTAL) - bus_wdata[SHARE_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker
    import nic_csr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input addr_t bus_addr,
    input logic  bus_we,
    input word_t bus_wdata,
    input word_t bus_rdata,
    input logic  bus_err,
    input word_t split_w,
    input word_t cause_w,
    input word_t mask_w,
    input word_t mgmt_w
);
    logic wr_ok;
    assign wr_ok = bus_we && !bus_err;

    AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_BUFSPLIT) |->
            (split_w[15:0] + split_w[31:16]) == 16'(BUF_TOTAL));  // R4

    AST_CAUSE_OR: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_CSET) |->
            (cause_w & $past(bus_wdata)) == $past(bus_wdata));  // R5

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_MSET) |->
            (mask_w & $past(bus_wdata)) == $past(bus_wdata));  // R6

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_MCLR) |->
            (mask_w & $past(bus_wdata)) == '0);  // R6

    AST_MGMT_READY: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_MGMT) |-> mgmt_w[28]);  // R7

    AST_MGMT_REJECT: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_ok && bus_addr == A_MGMT &&
              (bus_wdata[25:21] != SERVED_PHY || bus_wdata[29])) |->
            (mgmt_w[30] && mgmt_w[15:0] == 16'h0000));  // R8

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);  // R11

    AST_UNALIGNED: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> bus_err);  // R11
endmodule

bind nic_csr_bank nic_csr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .split_w   (split_q),
    .cause_w   (cause_q),
    .mask_w    (mask_q),
    .mgmt_w    (mgmt_q)
);

// File: tb/sim_nic_csr_bank.sv
`timescale 1ns/1ps
module sim_nic_csr_bank;
    import nic_csr_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    addr_t bus_addr = '0;
    logic  bus_we = 1'b0;
    word_t bus_wdata = '0;
    word_t bus_rdata;
    logic  bus_err;

    int total = 0;
    int failed = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    nic_csr_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    typedef struct packed {
        logic [15:0] wa;
        logic [31:0] wd;
        logic [15:0] ra;
        logic [31:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 32'h1234_5678, 16'h0000, 32'h1234_5678, 8'd2},  // R2
        '{16'h0008, 32'hDEAD_0001, 16'h0008, 32'hDEAD_0001, 8'd2},  // R2
        '{16'h2800, 32'hFFFF_FFFF, 16'h2800, 32'hFFFF_FFF0, 8'd3},  // R3
        '{16'h2808, 32'h0001_23FF, 16'h2808, 32'h0001_2380, 8'd3},  // R3
        '{16'h3800, 32'h1234_567F, 16'h3800, 32'h1234_5670, 8'd3},  // R3
        '{16'h3808, 32'h0000_00FF, 16'h3808, 32'h0000_0080, 8'd3},  // R3
        '{16'h3818, 32'h0000_00FF, 16'h3818, 32'h0000_00FF, 8'd3},  // R3
        '{16'h3804, 32'hABCD_0001, 16'h2800, 32'hFFFF_FFF0, 8'd3},  // R3
        '{16'h1000, 32'h0000_0020, 16'h1000, 32'h0020_0020, 8'd4},  // R4
        '{16'h1000, 32'hFFFF_0050, 16'h1000, 32'hFFF0_0050, 8'd4},  // R4
        '{16'h00C0, 32'h0000_0011, 16'h00C0, 32'h0000_0011, 8'd5},  // R5
        '{16'h00C8, 32'h0000_0104, 16'h00C0, 32'h0000_0115, 8'd5},  // R5
        '{16'h00C0, 32'h0000_0002, 16'h00C0, 32'h0000_0002, 8'd5},  // R5
        '{16'h00D0, 32'h0000_00F0, 16'h00D0, 32'h0000_00F0, 8'd6},  // R6
        '{16'h00D0, 32'h0000_0301, 16'h00D0, 32'h0000_03F1, 8'd6},  // R6
        '{16'h00D8, 32'h0000_0110, 16'h00D0, 32'h0000_02E1, 8'd6},  // R6
        '{16'h0020, 32'h0021_0000, 16'h0020, 32'h1021_796D, 8'd7},  // R7
        '{16'h0020, 32'h0022_0000, 16'h0020, 32'h1022_02A8, 8'd7},  // R7
        '{16'h0020, 32'h0023_0000, 16'h0020, 32'h1023_0380, 8'd7},  // R7
        '{16'h0020, 32'h002A_0000, 16'h0020, 32'h102A_7C00, 8'd7},  // R7
        '{16'h0020, 32'h002F_0000, 16'h0020, 32'h102F_3000, 8'd7},  // R7
        '{16'h0020, 32'h0034_0000, 16'h0020, 32'h1034_0180, 8'd7},  // R7
        '{16'h0020, 32'h0425_FFFF, 16'h0020, 32'h1425_0000, 8'd7},  // R7
        '{16'h0020, 32'h0041_0000, 16'h0020, 32'h5041_0000, 8'd8},  // R8
        '{16'h0020, 32'h2021_0000, 16'h0020, 32'h7021_0000, 8'd8},  // R8
        '{16'h0028, 32'hFFFF_FFFF, 16'h0000, 32'h1234_5678, 8'd9},  // R9
        '{16'h5800, 32'hFFFF_FFFF, 16'h5800, 32'h0000_0000, 8'd9},  // R9
        '{16'h0E00, 32'hFFFF_FFFF, 16'h0E00, 32'h0000_0000, 8'd9},  // R9
        '{16'h5604, 32'hFFFF_FFFF, 16'h5604, 32'h0000_0000, 8'd10}, // R10
        '{16'h5210, 32'hFFFF_FFFF, 16'h5210, 32'h0000_0000, 8'd10}, // R10
        '{16'h0410, 32'hFFFF_FFFF, 16'h4010, 32'h0000_0000, 8'd10}, // R10
        '{16'h0004, 32'hFFFF_FFFF, 16'h0008, 32'hDEAD_0001, 8'd12}  // R12
    };

    task automatic do_write(input addr_t a, input word_t d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic check_rd(input addr_t a, input word_t ex, input int rq);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== ex || bus_err !== 1'b0) begin
            failed++;
            $display("FAIL R%0d read 0x%04h: got 0x%08h err %0b, expected 0x%08h err 0",
                     rq, a, bus_rdata, bus_err, ex);
        end
    endtask

    task automatic check_err(input addr_t a, input logic we, input logic ex, input int rq);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = 32'hFFFF_FFFF;
        #1;
        total++;
        if (bus_err !== ex || (ex && bus_rdata !== '0)) begin
            failed++;
            $display("FAIL R%0d err at 0x%04h we %0b: got err %0b data 0x%08h, expected err %0b",
                     rq, a, we, bus_err, bus_rdata, ex);
        end
        bus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check_rd(A_CTRL,     32'h0000_0A09, 1);
        check_rd(A_STATUS,   32'h0000_00C1, 1);
        check_rd(A_BUFSPLIT, 32'h0010_0030, 1);
        check_rd(A_MGMT,     32'h0, 1);
        check_rd(A_CAUSE,    32'h0, 1);
        check_rd(A_MSET,     32'h0, 1);
        check_rd(16'h2800,   32'h0, 1);
        check_rd(16'h3818,   32'h0, 1);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].wa, VEC[i].wd);
            check_rd(VEC[i].ra, VEC[i].ex, int'(VEC[i].req));
        end

        // R11 decode errors
        check_err(16'h0004, 1'b0, 1'b1, 11);
        check_err(16'h0002, 1'b0, 1'b1, 11);
        check_err(A_CSET,   1'b0, 1'b1, 11);
        check_err(A_MCLR,   1'b0, 1'b1, 11);
        check_err(A_FC_LO,  1'b0, 1'b1, 11);
        check_err(16'h4010, 1'b1, 1'b1, 11);
        check_err(16'h4010, 1'b0, 1'b0, 10);
        check_err(16'h5604, 1'b1, 1'b0, 10);
        check_err(16'h5410, 1'b0, 1'b0, 10);

        // R12 unaligned write to control must not land
        do_write(16'h0001, 32'h0BAD_0BAD);
        check_rd(A_CTRL, 32'h1234_5678, 12);

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_rd(A_CTRL,     32'h0000_0A09, 1);
        check_rd(A_BUFSPLIT, 32'h0010_0030, 1);
        check_rd(A_MSET,     32'h0, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule